// File: doc/BRIEF.md
# Codec Verb Scratch Register Block with Format-Change Interrupt

This block sits on the codec side of an audio link. The host drives it through 12-bit command verbs. Each command carries a node ID and an 8-bit payload. The block holds two 32-bit scratch registers. A read verb returns a whole register. Each write verb loads exactly one byte of one register.

Scratch register 0 carries the current stream format to a display-side consumer:

- Bits 15:0 hold the format code.
- Bit 30 flags that the code is valid.
- Bits 29:16 have no meaning.
- A zero code with bit 30 cleared tells the consumer to turn audio off.

The consumer learns of a change through a sticky interrupt line, which it clears with an acknowledge pulse. How the interrupt is raised depends on the `NEW_MODE` parameter:

- **Legacy mode (`NEW_MODE`=0).** The registers answer at the function-group node 0x01. A byte-3 write to scratch 0 raises the interrupt when it flips bit 31, in either direction.
- **Newer mode (`NEW_MODE`=1).** The registers answer at the converter node `CVT_NODE`. Bit 31 is plain storage. The interrupt comes from a non-zero payload written to the host-interrupt verb 0xF80.

The interrupt is held in a two-state machine with these states and transitions:

- `IRQ_IDLE` moves to `IRQ_PEND` on *raise*, which is a trigger with no acknowledge in the same cycle.
- `IRQ_PEND` moves back to `IRQ_IDLE` on *clear*, which is the acknowledge.
- In all other cases the machine *holds* its state.

Top module: `verb_scratch_irq`

## Requirements
- R1: A read verb (0xFA6 for scratch 0, 0xFAB for scratch 1) at the answering node puts the full 32-bit register on `rsp_data`, with `rsp_valid` high, in the cycle after the command strobe.
- R2: Verbs 0xFA7..0xFAA write bytes 0..3 of scratch 0, and 0xFAC..0xFAF write bytes 0..3 of scratch 1. Byte n is bits 8n+7:8n. Other bytes are unchanged, and the response is zero.
- R3: `fmt_code` always equals scratch 0 bits 15:0, and `fmt_valid` always equals scratch 0 bit 30.
- R4: In legacy mode, a byte-3 write to scratch 0 whose payload bit 7 differs from the current bit 31 raises `irq` in the next cycle. Both directions count. Rewriting the same bit value raises nothing.
- R5: In the newer mode, writing a non-zero payload to verb 0xF80 raises `irq`. A zero payload does not. Changes of bit 31 do not.
- R6: Registers answer only at node 0x01 in legacy mode, and only at `CVT_NODE` in the newer mode. A command to any other node changes nothing and returns a zero response.
- R7: Unrecognised verbs change nothing and return a zero response. In legacy mode, 0xF80 is one of them.
- R8: Once raised, `irq` stays high until `irq_ack` is pulsed. When an acknowledge and a trigger fall in the same cycle, the acknowledge wins and `irq` goes low.
- R9: While `rst_n` is low at a clock edge, both registers, `irq` and `rsp_valid` are cleared (synchronous reset).
- R10: `rsp_valid` is high exactly in the cycle after a cycle with `cmd_valid` high, whatever the node or verb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_node | input | 8 | Target node ID |
| cmd_verb | input | 12 | Verb code |
| cmd_data | input | 8 | Payload byte |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | 32 | Response word |
| scratch0 | output | 32 | Scratch register 0 |
| scratch1 | output | 32 | Scratch register 1 |
| fmt_valid | output | 1 | Format-valid flag (scratch 0 bit 30) |
| fmt_code | output | 16 | Format code (scratch 0 bits 15:0) |
| irq | output | 1 | Sticky interrupt to the consumer |
| irq_ack | input | 1 | Interrupt acknowledge |

## Verification
An acknowledge can meet a new trigger in the same cycle. The bench provokes this by pulsing `irq_ack` together with a byte-3 write that flips bit 31, and separately with a non-zero 0xF80 write in the newer-mode instance. In both cases it expects `irq` low on the next cycle. A write to scratch 0 can also coincide with the toggle decision, which must compare against the old bit 31. The per-clock reference model computes that decision from the value held before the write.

// File: rtl/vsi_pkg.sv
package vsi_pkg;
    localparam int          NODE_W        = 8;
    localparam int          VERB_W        = 12;
    localparam int          REG_W         = 32;
    localparam int          NUM_REGS      = 2;
    localparam int          BYTES_PER_REG = REG_W / 8;
    localparam int          IDX_W         = $clog2(BYTES_PER_REG);

    localparam logic [NODE_W-1:0] FUNC_GROUP_NODE = 8'h01;

    localparam logic [VERB_W-1:0] V_READ0    = 12'hFA6;
    localparam logic [VERB_W-1:0] V_WR0_BASE = 12'hFA7;
    localparam logic [VERB_W-1:0] V_READ1    = 12'hFAB;
    localparam logic [VERB_W-1:0] V_WR1_BASE = 12'hFAC;
    localparam logic [VERB_W-1:0] V_HOST_IRQ = 12'hF80;

    localparam int TOGGLE_BIT = 31;
    localparam int VALID_BIT  = 30;

    typedef enum logic {IRQ_IDLE = 1'b0, IRQ_PEND = 1'b1} irq_state_e;
endpackage

// File: rtl/vsi_decode.sv
module vsi_decode
    import vsi_pkg::*;
#(
    parameter bit                NEW_MODE = 1'b0,
    parameter logic [NODE_W-1:0] CVT_NODE = 8'h04
) (
    input  logic              cmd_valid,
    input  logic [NODE_W-1:0] cmd_node,
    input  logic [VERB_W-1:0] cmd_verb,
    output logic              node_hit,
    output logic [NUM_REGS-1:0] rd_sel,
    output logic [NUM_REGS-1:0] wr_sel,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              host_irq_wr
);
    logic [NODE_W-1:0] answer_node;
    logic [VERB_W-1:0] off0, off1;

    generate
        if (NEW_MODE) begin : g_cvt_node
            assign answer_node = CVT_NODE;
        end else begin : g_fg_node
            assign answer_node = FUNC_GROUP_NODE;
        end
    endgenerate

    always_comb begin
        node_hit    = cmd_valid && (cmd_node == answer_node);
        off0        = cmd_verb - V_WR0_BASE;
        off1        = cmd_verb - V_WR1_BASE;
        rd_sel      = '0;
        wr_sel      = '0;
        wr_idx      = '0;
        host_irq_wr = 1'b0;
        if (node_hit) begin
            rd_sel[0] = (cmd_verb == V_READ0);
            rd_sel[1] = (cmd_verb == V_READ1);
            if (cmd_verb >= V_WR0_BASE && off0 < VERB_W'(BYTES_PER_REG)) begin
                wr_sel[0] = 1'b1;
                wr_idx    = off0[IDX_W-1:0];
            end
            if (cmd_verb >= V_WR1_BASE && off1 < VERB_W'(BYTES_PER_REG)) begin
                wr_sel[1] = 1'b1;
                wr_idx    = off1[IDX_W-1:0];
            end
            host_irq_wr = NEW_MODE && (cmd_verb == V_HOST_IRQ);
        end
    end
endmodule

// File: rtl/vsi_bank.sv
module vsi_bank
    import vsi_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REGS-1:0] wr_sel,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [7:0]          wr_byte,
    output logic [REG_W-1:0]    regs [NUM_REGS]
);
    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            for (genvar b = 0; b < BYTES_PER_REG; b++) begin : g_byte
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        regs[r][b*8 +: 8] <= '0;
                    else if (wr_sel[r] && wr_idx == IDX_W'(b))
                        regs[r][b*8 +: 8] <= wr_byte;
                end
            end
        end
    endgenerate

    p_single_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));
endmodule

// File: rtl/vsi_irq.sv
module vsi_irq
    import vsi_pkg::*;
#(
    parameter bit NEW_MODE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic top_byte_wr,
    input  logic new_b31,
    input  logic old_b31,
    input  logic host_irq_wr,
    input  logic payload_nz,
    input  logic irq_ack,
    output logic irq
);
    irq_state_e state, state_nx;
    logic       trig;

    always_comb begin
        if (NEW_MODE)
            trig = host_irq_wr && payload_nz;
        else
            trig = top_byte_wr && (new_b31 != old_b31);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= IRQ_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            IRQ_IDLE: if (trig && !irq_ack) state_nx = IRQ_PEND;
            IRQ_PEND: if (irq_ack)          state_nx = IRQ_IDLE;
            default:                        state_nx = IRQ_IDLE;
        endcase
    end

    always_comb irq = (state == IRQ_PEND);

    p_ack_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq);
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);
endmodule

// File: rtl/verb_scratch_irq.sv
module verb_scratch_irq
    import vsi_pkg::*;
#(
    parameter bit                NEW_MODE = 1'b0,
    parameter logic [NODE_W-1:0] CVT_NODE = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [NODE_W-1:0] cmd_node,
    input  logic [VERB_W-1:0] cmd_verb,
    input  logic [7:0]        cmd_data,
    output logic              rsp_valid,
    output logic [REG_W-1:0]  rsp_data,
    output logic [REG_W-1:0]  scratch0,
    output logic [REG_W-1:0]  scratch1,
    output logic              fmt_valid,
    output logic [15:0]       fmt_code,
    output logic              irq,
    input  logic              irq_ack
);
    logic                node_hit;
    logic [NUM_REGS-1:0] rd_sel, wr_sel;
    logic [IDX_W-1:0]    wr_idx;
    logic                host_irq_wr;
    logic [REG_W-1:0]    regs [NUM_REGS];
    logic [REG_W-1:0]    rd_word;

    vsi_decode #(.NEW_MODE(NEW_MODE), .CVT_NODE(CVT_NODE)) u_dec (
        .cmd_valid  (cmd_valid),
        .cmd_node   (cmd_node),
        .cmd_verb   (cmd_verb),
        .node_hit   (node_hit),
        .rd_sel     (rd_sel),
        .wr_sel     (wr_sel),
        .wr_idx     (wr_idx),
        .host_irq_wr(host_irq_wr)
    );

    vsi_bank u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (wr_sel),
        .wr_idx (wr_idx),
        .wr_byte(cmd_data),
        .regs   (regs)
    );

    vsi_irq #(.NEW_MODE(NEW_MODE)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .top_byte_wr(wr_sel[0] && wr_idx == IDX_W'(BYTES_PER_REG - 1)),
        .new_b31    (cmd_data[7]),
        .old_b31    (regs[0][TOGGLE_BIT]),
        .host_irq_wr(host_irq_wr),
        .payload_nz (cmd_data != 8'h00),
        .irq_ack    (irq_ack),
        .irq        (irq)
    );

    always_comb begin
        rd_word = '0;
        for (int r = 0; r < NUM_REGS; r++)
            if (rd_sel[r]) rd_word = regs[r];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= cmd_valid;
            rsp_data  <= rd_word;
        end
    end

    assign scratch0  = regs[0];
    assign scratch1  = regs[1];
    assign fmt_code  = regs[0][15:0];
    assign fmt_valid = regs[0][VALID_BIT];

    p_rsp_follows_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);
    p_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid);
    p_foreign_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !node_hit) |=> (rsp_data == '0 && $stable(scratch0) && $stable(scratch1)));
    p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cmd_valid && !irq_ack));
    p_mode_trigger_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (NEW_MODE && cmd_verb != V_HOST_IRQ) |=> !$rose(irq));
    p_legacy_f80_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!NEW_MODE && cmd_valid && cmd_verb == V_HOST_IRQ && !irq) |=> !irq);
endmodule

// File: tb/sim_verb_scratch_irq.sv
module sim_verb_scratch_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_node = '0;
    logic [11:0] cmd_verb = '0;
    logic [7:0]  cmd_data = '0;
    logic        irq_ack = 1'b0;

    logic        o_rv [2];
    logic [31:0] o_rd [2];
    logic [31:0] o_s0 [2];
    logic [31:0] o_s1 [2];
    logic        o_fv [2];
    logic [15:0] o_fc [2];
    logic        o_irq [2];

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    verb_scratch_irq #(.NEW_MODE(1'b0), .CVT_NODE(8'h04)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_node(cmd_node),
        .cmd_verb(cmd_verb), .cmd_data(cmd_data), .rsp_valid(o_rv[0]),
        .rsp_data(o_rd[0]), .scratch0(o_s0[0]), .scratch1(o_s1[0]),
        .fmt_valid(o_fv[0]), .fmt_code(o_fc[0]), .irq(o_irq[0]), .irq_ack(irq_ack));

    verb_scratch_irq #(.NEW_MODE(1'b1), .CVT_NODE(8'h04)) u1 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_node(cmd_node),
        .cmd_verb(cmd_verb), .cmd_data(cmd_data), .rsp_valid(o_rv[1]),
        .rsp_data(o_rd[1]), .scratch0(o_s0[1]), .scratch1(o_s1[1]),
        .fmt_valid(o_fv[1]), .fmt_code(o_fc[1]), .irq(o_irq[1]), .irq_ack(irq_ack));

    // behavioural reference model: index 0 legacy, index 1 newer mode
    logic [31:0] m_s0 [2];
    logic [31:0] m_s1 [2];
    logic [31:0] m_rd [2];
    logic        m_rv [2];
    logic        m_irq [2];

    always @(posedge clk) begin
        for (int m = 0; m < 2; m++) begin
            bit hit, trig;
            int k;
            if (!rst_n) begin
                m_s0[m] = 0; m_s1[m] = 0; m_rd[m] = 0; m_rv[m] = 0; m_irq[m] = 0;
            end else begin
                hit  = cmd_valid && (cmd_node == ((m == 1) ? 8'h04 : 8'h01));
                trig = 0;
                m_rd[m] = 0;
                if (hit) begin
                    if (cmd_verb == 12'hFA6) m_rd[m] = m_s0[m];
                    if (cmd_verb == 12'hFAB) m_rd[m] = m_s1[m];
                    if (cmd_verb >= 12'hFA7 && cmd_verb <= 12'hFAA) begin
                        k = int'(cmd_verb) - 'hFA7;
                        if (m == 0 && k == 3 && cmd_data[7] != m_s0[m][31]) trig = 1;
                        m_s0[m][k*8 +: 8] = cmd_data;
                    end
                    if (cmd_verb >= 12'hFAC && cmd_verb <= 12'hFAF) begin
                        k = int'(cmd_verb) - 'hFAC;
                        m_s1[m][k*8 +: 8] = cmd_data;
                    end
                    if (m == 1 && cmd_verb == 12'hF80 && cmd_data != 0) trig = 1;
                end
                m_rv[m] = cmd_valid;
                if (irq_ack)   m_irq[m] = 0;
                else if (trig) m_irq[m] = 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        for (int m = 0; m < 2; m++) begin
            check(o_rv[m] == m_rv[m], "R10 rsp_valid", 32'(o_rv[m]), 32'(m_rv[m]));
            check(o_rd[m] == m_rd[m], "R1 rsp_data", o_rd[m], m_rd[m]);
            check(o_s0[m] == m_s0[m], "R2 scratch0", o_s0[m], m_s0[m]);
            check(o_s1[m] == m_s1[m], "R2 scratch1", o_s1[m], m_s1[m]);
            check(o_fc[m] == m_s0[m][15:0], "R3 fmt_code", 32'(o_fc[m]), 32'(m_s0[m][15:0]));
            check(o_fv[m] == m_s0[m][30], "R3 fmt_valid", 32'(o_fv[m]), 32'(m_s0[m][30]));
            check(o_irq[m] == m_irq[m], "R8 irq", 32'(o_irq[m]), 32'(m_irq[m]));
        end
    endtask

    task automatic step(input logic v, input logic [7:0] n, input logic [11:0] vb,
                        input logic [7:0] d, input logic a);
        cmd_valid = v; cmd_node = n; cmd_verb = vb; cmd_data = d; irq_ack = a;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        step(1'b0, 8'h00, 12'h000, 8'h00, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        @(negedge clk);
        step(1'b0, 8'h00, 12'h000, 8'h00, 1'b0);
        // R9: reset state
        check(o_s0[0] == 0 && o_s1[0] == 0 && !o_irq[0] && !o_rv[0], "R9 reset", o_s0[0], 0);
        rst_n = 1'b1;
        idle();

        // legacy instance at node 0x01
        step(1, 8'h01, 12'hFA7, 8'h34, 0);
        check(o_s0[0] == 32'h34, "R2 byte0", o_s0[0], 32'h34);
        check(o_s0[1] == 0, "R6 foreign node", o_s0[1], 0);
        step(1, 8'h01, 12'hFA8, 8'h12, 0);
        check(o_fc[0] == 16'h1234, "R3 fmt", 32'(o_fc[0]), 32'h1234);
        step(1, 8'h01, 12'hFAA, 8'h40, 0);
        check(o_fv[0] && !o_irq[0], "R4 no toggle", 32'(o_irq[0]), 0);
        step(1, 8'h01, 12'hFAA, 8'hC0, 0);
        check(o_irq[0] == 1, "R4 rise toggle", 32'(o_irq[0]), 1);
        idle();
        check(o_irq[0] == 1, "R8 sticky", 32'(o_irq[0]), 1);
        step(0, 8'h00, 12'h000, 8'h00, 1);
        check(o_irq[0] == 0, "R8 ack", 32'(o_irq[0]), 0);
        step(1, 8'h01, 12'hFAA, 8'hC0, 0);
        check(o_irq[0] == 0, "R4 same value", 32'(o_irq[0]), 0);
        step(1, 8'h01, 12'hFAA, 8'h00, 1);
        check(o_irq[0] == 0, "R8 ack beats trigger", 32'(o_irq[0]), 0);
        step(1, 8'h01, 12'hFAA, 8'h80, 0);
        check(o_irq[0] == 1, "R4 toggle back", 32'(o_irq[0]), 1);
        step(1, 8'h01, 12'hFA6, 8'h00, 1);
        check(o_rv[0] && o_rd[0] == 32'h80001234, "R1 read s0", o_rd[0], 32'h80001234);
        step(1, 8'h01, 12'hFB0, 8'hFF, 0);
        check(o_rv[0] && o_rd[0] == 0 && o_s0[0] == 32'h80001234, "R7 unknown verb", o_rd[0], 0);
        step(1, 8'h01, 12'hF80, 8'h01, 0);
        check(o_irq[0] == 0, "R7 f80 legacy", 32'(o_irq[0]), 0);
        step(1, 8'h09, 12'hFA7, 8'hEE, 0);
        check(o_rd[0] == 0 && o_s0[0] == 32'h80001234, "R6 other node", o_s0[0], 32'h80001234);

        // newer-mode instance at node 0x04
        step(1, 8'h04, 12'hF80, 8'h00, 0);
        check(o_irq[1] == 0, "R5 zero payload", 32'(o_irq[1]), 0);
        step(1, 8'h04, 12'hF80, 8'h01, 0);
        check(o_irq[1] == 1, "R5 host verb", 32'(o_irq[1]), 1);
        step(1, 8'h04, 12'hF80, 8'h02, 1);
        check(o_irq[1] == 0, "R8 ack beats host verb", 32'(o_irq[1]), 0);
        step(1, 8'h04, 12'hFAA, 8'h80, 0);
        check(o_irq[1] == 0 && o_s0[1] == 32'h80000000, "R5 bit31 silent", o_s0[1], 32'h80000000);
        step(1, 8'h04, 12'hFAD, 8'h5A, 0);
        check(o_s1[1] == 32'h5A00, "R2 s1 byte1", o_s1[1], 32'h5A00);
        step(1, 8'h04, 12'hFAB, 8'h00, 0);
        check(o_rd[1] == 32'h5A00, "R1 read s1", o_rd[1], 32'h5A00);
        idle();
        check(o_rv[0] == 0 && o_rv[1] == 0, "R10 idle", 32'(o_rv[0]), 0);

        // randomised traffic against the model
        for (int i = 0; i < 2000; i++) begin
            logic [7:0] nd;
            int sel = $urandom_range(0, 3);
            nd = (sel == 0) ? 8'h01 : (sel == 1) ? 8'h04 : (sel == 2) ? 8'h01 : 8'h07;
            step(1'($urandom_range(0, 3) != 0), nd, 12'hF80 + 12'($urandom_range(0, 52)),
                 8'($urandom), 1'($urandom_range(0, 5) == 0));
        end

        rst_n = 1'b0;
        idle();
        check(o_s0[0] == 0 && o_s1[1] == 0 && !o_irq[0] && !o_irq[1], "R9 mid reset", o_s0[0], 0);
        rst_n = 1'b1;
        idle();

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule